// File: doc/BRIEF.md
# First-Active-Bit Mask Fill Unit

This unit builds a new destination mask from the first active set bit of a source mask. It has three fill modes. Fill-before writes ones on active elements that lie below the first active set bit. Fill-including also writes a one at that bit. Fill-only writes a one at that bit alone. A single start pulse carries the operation: the source mask, the old destination, the element-enable mask, the masking control, the vector length, the start element, the two register indices, and the mode. The unit also receives two flags, one saying whether vector execution is enabled and one saying whether the current element type is valid.

The unit first checks whether the operation is legal. An illegal operation ends at once with a fault. A legal one captures its operands. The unit then walks the elements one per cycle, from element 0 up to the element below the length. A one-bit flag records whether the first active set bit has already been passed. Elements that are masked off keep their old value. Elements at or above the length also keep their old value. When the scan ends, the unit presents the finished mask and pulses done, dirty and start-index-clear together.

The controller has four states. IDLE waits for start. SCAN processes one element per cycle. FINISH is a one-cycle successful completion. FAULT is a one-cycle illegal completion. Its transitions are:
- accept-legal: IDLE to SCAN.
- accept-illegal: IDLE to FAULT.
- step: SCAN to SCAN, while the index is below the length.
- scan-end: SCAN to FINISH, when the index equals the length.
- retire: FINISH to IDLE.
- reject-retire: FAULT to IDLE.

Top module: `mask_first_fill`

## Requirements
- R1: Mode 2'b00 (fill-before) writes 1 on every active element below the first active set source bit, and 0 on that element and every active element above it. A first set bit at element 3 with length 8 and old value 0 gives 128'h7.
- R2: Mode 2'b01 (fill-including) writes 1 on every active element up to and including the first active set source bit, and 0 on the active elements above it.
- R3: Mode 2'b10 (fill-only) writes 1 only on the first active set source bit, and 0 on every other active element.
- R4: When no active element has its source bit set, modes 2'b00 and 2'b01 write 1 on every active element, and mode 2'b10 writes 0 on every active element.
- R5: Element i is active when `unmasked` is 1 or `en_mask[i]` is 1. An inactive element keeps `old_dst[i]`, and its source bit is ignored when the first set bit is located.
- R6: Bits at index `vec_len` and above keep `old_dst`. With `vec_len` 0 the result equals `old_dst`, and the operation still completes legally with a dirty pulse.
- R7: An operation is illegal in any of these cases: `vec_on` is 0; `type_ok` is 0; `start_elem` is nonzero; `dst_idx` equals `src_idx`; `dst_idx` is 0 while `unmasked` is 0; the mode is 2'b11; or `vec_len` exceeds MASK_W. An illegal operation raises `done` and `illegal` for one cycle, in the cycle after start is sampled. It gives no dirty or start-clear pulse, and `dst_out` equals the `old_dst` presented with start.
- R8: A legal operation raises `done`, `dirty_pulse` and `start_clr` together for exactly one cycle, `vec_len`+2 cycles after the cycle in which start is sampled. `dst_out` then holds the result until the next accepted start.
- R9: A start asserted while `busy` is 1 is ignored, and the running operation finishes with its original operands and timing.
- R10: During reset, `busy`, `done`, `illegal`, `dirty_pulse` and `start_clr` are 0 and `dst_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, sampled in IDLE |
| mode | input | 2 | Fill mode: 00 before, 01 including, 10 only, 11 reserved (illegal) |
| src_mask | input | MASK_W | Source mask searched for its first active set bit |
| old_dst | input | MASK_W | Previous destination mask contents |
| en_mask | input | MASK_W | Element-enable mask, used when unmasked is 0 |
| unmasked | input | 1 | 1: all elements are active |
| vec_len | input | LEN_W | Number of elements processed |
| start_elem | input | LEN_W | Start element index; must be 0 |
| dst_idx | input | REG_IDX_W | Destination register index |
| src_idx | input | REG_IDX_W | Source register index |
| vec_on | input | 1 | Vector execution enabled |
| type_ok | input | 1 | Element type setting valid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Completion was a fault |
| dirty_pulse | output | 1 | Vector state modified (legal completion) |
| start_clr | output | 1 | Clear the start element index (legal completion) |
| dst_out | output | MASK_W | Resulting destination mask |

## Verification
The hardest case to reach from the ports is a source bit that is set, at a low index, on an element that is masked off. In that case the unit must look past the bit and find a later active bit. This only shows up when the enable mask and a sparse source mask line up in a particular way. Directed cases build this alignment on purpose. Random operations, using sparse sources made by AND-ing several random words together, then cover many more alignments across all lengths. A second start issued in the middle of a scan, with inverted operands, is used to show that the captured operands cannot be disturbed.

// File: rtl/mff_pkg.sv
package mff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2,
        ST_FAULT  = 2'd3
    } mff_state_t;

    typedef enum logic [1:0] {
        FILL_BEFORE = 2'b00,
        FILL_INCL   = 2'b01,
        FILL_ONLY   = 2'b10,
        FILL_RSVD   = 2'b11
    } fill_mode_t;

endpackage

// File: rtl/mff_legal.sv
module mff_legal #(
    parameter int REG_IDX_W = 5,
    parameter int LEN_W     = 8,
    parameter int MASK_W    = 128
) (
    input  logic                 vec_on,
    input  logic                 type_ok,
    input  logic [LEN_W-1:0]     start_elem,
    input  logic [LEN_W-1:0]     vec_len,
    input  logic [REG_IDX_W-1:0] dst_idx,
    input  logic [REG_IDX_W-1:0] src_idx,
    input  logic                 unmasked,
    input  logic [1:0]           mode,
    output logic                 reject
);
    import mff_pkg::*;

    logic env_bad, overlap_bad, mask_bad, len_bad, mode_bad;

    always_comb begin
        env_bad     = !vec_on || !type_ok || (start_elem != '0);
        overlap_bad = (dst_idx == src_idx);
        mask_bad    = !unmasked && (dst_idx == '0);
        len_bad     = (vec_len > LEN_W'(MASK_W));
        mode_bad    = (mode == FILL_RSVD);
        reject      = env_bad || overlap_bad || mask_bad || len_bad || mode_bad;
    end
endmodule

// File: rtl/mff_step.sv
module mff_step (
    input  logic [1:0] mode,
    input  logic       active,
    input  logic       src_bit,
    input  logic       old_bit,
    input  logic       seen,
    output logic       new_bit,
    output logic       seen_nxt
);
    import mff_pkg::*;

    always_comb begin
        new_bit  = old_bit;
        seen_nxt = seen;
        if (active) begin
            unique case (mode)
                FILL_BEFORE: new_bit = !seen && !src_bit;
                FILL_INCL:   new_bit = !seen;
                FILL_ONLY:   new_bit = !seen && src_bit;
                default:     new_bit = old_bit;
            endcase
            seen_nxt = seen || src_bit;
        end
    end
endmodule

// File: rtl/mff_bitreg.sv
module mff_bitreg #(
    parameter int MASK_W = 128,
    localparam int POS_W = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MASK_W-1:0] load_val,
    input  logic              wr_en,
    input  logic [POS_W-1:0]  wr_idx,
    input  logic              wr_bit,
    output logic [MASK_W-1:0] q
);
    for (genvar b = 0; b < MASK_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else if (load) begin
                q[b] <= load_val[b];
            end else if (wr_en && (wr_idx == POS_W'(b))) begin
                q[b] <= wr_bit;
            end
        end
    end
endmodule

// File: rtl/mask_first_fill.sv
module mask_first_fill #(
    parameter int MASK_W    = 128,
    parameter int REG_IDX_W = 5,
    localparam int LEN_W    = $clog2(MASK_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           mode,
    input  logic [MASK_W-1:0]    src_mask,
    input  logic [MASK_W-1:0]    old_dst,
    input  logic [MASK_W-1:0]    en_mask,
    input  logic                 unmasked,
    input  logic [LEN_W-1:0]     vec_len,
    input  logic [LEN_W-1:0]     start_elem,
    input  logic [REG_IDX_W-1:0] dst_idx,
    input  logic [REG_IDX_W-1:0] src_idx,
    input  logic                 vec_on,
    input  logic                 type_ok,
    output logic                 busy,
    output logic                 done,
    output logic                 illegal,
    output logic                 dirty_pulse,
    output logic                 start_clr,
    output logic [MASK_W-1:0]    dst_out
);
    import mff_pkg::*;

    localparam int POS_W = $clog2(MASK_W);

    mff_state_t state_q, state_d;

    // captured operands
    logic [MASK_W-1:0] src_q;
    logic [MASK_W-1:0] en_q;
    logic [1:0]        mode_q;
    logic              unm_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    logic              seen_q;

    logic              reject;
    logic              accept;
    logic              scan_end;
    logic              stepping;
    logic [POS_W-1:0]  pos;
    logic              elem_active;
    logic              new_bit;
    logic              seen_nxt;
    logic [MASK_W-1:0] work_q;

    mff_legal #(
        .REG_IDX_W (REG_IDX_W),
        .LEN_W     (LEN_W),
        .MASK_W    (MASK_W)
    ) u_legal (
        .vec_on     (vec_on),
        .type_ok    (type_ok),
        .start_elem (start_elem),
        .vec_len    (vec_len),
        .dst_idx    (dst_idx),
        .src_idx    (src_idx),
        .unmasked   (unmasked),
        .mode       (mode),
        .reject     (reject)
    );

    assign accept   = (state_q == ST_IDLE) && start;
    assign scan_end = (idx_q == len_q);
    assign stepping = (state_q == ST_SCAN) && !scan_end;
    assign pos      = idx_q[POS_W-1:0];
    assign elem_active = unm_q || en_q[pos];

    mff_step u_step (
        .mode     (mode_q),
        .active   (elem_active),
        .src_bit  (src_q[pos]),
        .old_bit  (work_q[pos]),
        .seen     (seen_q),
        .new_bit  (new_bit),
        .seen_nxt (seen_nxt)
    );

    mff_bitreg #(
        .MASK_W (MASK_W)
    ) u_work (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (old_dst),
        .wr_en    (stepping),
        .wr_idx   (pos),
        .wr_bit   (new_bit),
        .q        (work_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = reject ? ST_FAULT : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (scan_end) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operand capture and scan position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            en_q   <= '0;
            mode_q <= FILL_BEFORE;
            unm_q  <= 1'b0;
            len_q  <= '0;
            idx_q  <= '0;
            seen_q <= 1'b0;
        end else if (accept) begin
            src_q  <= src_mask;
            en_q   <= en_mask;
            mode_q <= mode;
            unm_q  <= unmasked;
            len_q  <= vec_len;
            idx_q  <= '0;
            seen_q <= 1'b0;
        end else if (stepping) begin
            idx_q  <= idx_q + LEN_W'(1);
            seen_q <= seen_nxt;
        end
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        illegal     = 1'b0;
        dirty_pulse = 1'b0;
        start_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SCAN: busy = 1'b1;
            ST_FINISH: begin
                busy        = 1'b1;
                done        = 1'b1;
                dirty_pulse = 1'b1;
                start_clr   = 1'b1;
            end
            ST_FAULT: begin
                busy    = 1'b1;
                done    = 1'b1;
                illegal = 1'b1;
            end
            default: ;
        endcase
    end

    assign dst_out = work_q;

endmodule

// File: rtl/mff_checker.sv
module mff_checker #(
    parameter int MASK_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              dirty_pulse,
    input logic              start_clr,
    input logic [MASK_W-1:0] old_dst,
    input logic [MASK_W-1:0] dst_out
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_FAULT_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> (done && !dirty_pulse && !start_clr)); // R7
    AST_FAULT_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> (dst_out == $past(old_dst))); // R7
    AST_FAULT_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> ($past(start) && !$past(busy))); // R7
    AST_DIRTY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) dirty_pulse |-> (done && start_clr && !illegal)); // R8
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !$past(busy)) |-> $stable(dst_out)); // R8

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (!busy && !done && !illegal && !dirty_pulse && !start_clr); // R10
        end
    end
endmodule

bind mask_first_fill mff_checker #(.MASK_W(MASK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .illegal     (illegal),
    .dirty_pulse (dirty_pulse),
    .start_clr   (start_clr),
    .old_dst     (old_dst),
    .dst_out     (dst_out)
);

// File: tb/tb_mask_first_fill.sv
module tb_mask_first_fill;
    localparam int W = 128;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [W-1:0]  src_mask = '0;
    logic [W-1:0]  old_dst = '0;
    logic [W-1:0]  en_mask = '0;
    logic          unmasked = 1'b1;
    logic [LW-1:0] vec_len = '0;
    logic [LW-1:0] start_elem = '0;
    logic [4:0]    dst_idx = 5'd4;
    logic [4:0]    src_idx = 5'd2;
    logic          vec_on = 1'b1;
    logic          type_ok = 1'b1;
    logic          busy, done, illegal, dirty_pulse, start_clr;
    logic [W-1:0]  dst_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] r_dst;
    logic         r_ill, r_dirty, r_clr;
    int           r_lat;

    always #10 clk = ~clk;

    mask_first_fill dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .src_mask(src_mask), .old_dst(old_dst), .en_mask(en_mask),
        .unmasked(unmasked), .vec_len(vec_len), .start_elem(start_elem),
        .dst_idx(dst_idx), .src_idx(src_idx), .vec_on(vec_on), .type_ok(type_ok),
        .busy(busy), .done(done), .illegal(illegal), .dirty_pulse(dirty_pulse),
        .start_clr(start_clr), .dst_out(dst_out)
    );

    function automatic logic [W-1:0] ref_fill(input logic [1:0] m, input logic [W-1:0] s,
                                              input logic [W-1:0] o, input logic [W-1:0] en,
                                              input logic vm, input int vl);
        logic [W-1:0] r;
        logic seen;
        r = o;
        seen = 1'b0;
        for (int i = 0; i < vl; i++) begin
            if (vm || en[i]) begin
                case (m)
                    2'b00: r[i] = !seen && !s[i];
                    2'b01: r[i] = !seen;
                    default: r[i] = !seen && s[i];
                endcase
                if (s[i]) seen = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic chk_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [W-1:0] s, input logic [W-1:0] o,
                          input logic [W-1:0] en, input logic vm, input int vl, input bit bump);
        @(negedge clk);
        mode = m; src_mask = s; old_dst = o; en_mask = en; unmasked = vm;
        vec_len = LW'(vl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_lat = 1;
        while (!done && r_lat < 400) begin
            @(negedge clk);
            r_lat++;
            if (bump && r_lat == 2 && !done) begin
                start = 1'b1; src_mask = ~s; mode = 2'b01; unmasked = 1'b1; vec_len = LW'(3);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: no done, got 0 expected 1");
        end
        r_dst = dst_out; r_ill = illegal; r_dirty = dirty_pulse; r_clr = start_clr;
        @(negedge clk);
    endtask

    task automatic legal_op(input string req, input logic [1:0] m, input logic [W-1:0] s,
                            input logic [W-1:0] o, input logic [W-1:0] en, input logic vm,
                            input int vl, input bit bump);
        run_op(m, s, o, en, vm, vl, bump);
        chk_vec(req, r_dst, ref_fill(m, s, o, en, vm, vl));
        chk_int({req, " R8 latency"}, r_lat, vl + 2);
        chk_int({req, " R8 dirty/clear"}, int'({r_ill, r_dirty, r_clr}), 3);
    endtask

    task automatic bad_op(input string req, input logic [1:0] m, input logic vm);
        logic [W-1:0] o;
        o = {$urandom, $urandom, $urandom, $urandom};
        run_op(m, {W{1'b1}}, o, {W{1'b1}}, vm, 8, 1'b0);
        chk_int({req, " illegal flags"}, int'({r_ill, r_dirty, r_clr}), 4);
        chk_int({req, " latency"}, r_lat, 1);
        chk_vec({req, " dst kept"}, r_dst, o);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] ones;
        ones = {W{1'b1}};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk_int("R10 reset flags", int'({busy, done, illegal, dirty_pulse, start_clr}), 0);
        chk_vec("R10 reset dst", dst_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 fill-before, first bit at element 3
        run_op(2'b00, 128'h8, '0, '0, 1'b1, 8, 1'b0);
        chk_vec("R1 before pos3", r_dst, 128'h7);
        // R2 fill-including
        run_op(2'b01, 128'h8, '0, '0, 1'b1, 8, 1'b0);
        chk_vec("R2 incl pos3", r_dst, 128'hF);
        // R3 fill-only
        run_op(2'b10, 128'h48, '0, '0, 1'b1, 8, 1'b0);
        chk_vec("R3 only pos3", r_dst, 128'h8);
        // R4 no set bit
        run_op(2'b00, '0, '0, '0, 1'b1, 8, 1'b0);
        chk_vec("R4 before none", r_dst, 128'hFF);
        run_op(2'b01, '0, '0, '0, 1'b1, 8, 1'b0);
        chk_vec("R4 incl none", r_dst, 128'hFF);
        run_op(2'b10, '0, ones, '0, 1'b1, 8, 1'b0);
        chk_vec("R4 only none", r_dst, ~128'hFF);
        // R5 masked elements undisturbed, hidden source bit skipped
        run_op(2'b00, 128'h10, ones, 128'hFC, 1'b0, 8, 1'b0);
        chk_vec("R5 masked before", r_dst, ~128'hF0);
        run_op(2'b10, 128'h11, '0, 128'hFC, 1'b0, 8, 1'b0);
        chk_vec("R5 masked only skips bit0", r_dst, 128'h10);
        run_op(2'b01, 128'h5, ones, 128'hFC, 1'b0, 8, 1'b0);
        chk_vec("R5 masked incl", r_dst, ~128'hF8);
        // R6 tail and zero length
        run_op(2'b00, '0, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA, '0, 1'b1, 0, 1'b0);
        chk_vec("R6 len0 unchanged", r_dst, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA);
        chk_int("R6 len0 legal dirty", int'({r_ill, r_dirty}), 1);
        chk_int("R6 len0 latency", r_lat, 2);
        legal_op("R6 tail kept", 2'b01, 128'h0, ones, '0, 1'b1, 5, 1'b0);
        legal_op("R6 full length", 2'b00, 128'h1 << 127, '0, '0, 1'b1, 128, 1'b0);
        // R7 illegal cases
        vec_on = 1'b0;     bad_op("R7 disabled", 2'b00, 1'b1); vec_on = 1'b1;
        type_ok = 1'b0;    bad_op("R7 bad type", 2'b01, 1'b1); type_ok = 1'b1;
        start_elem = 8'd1; bad_op("R7 start nonzero", 2'b10, 1'b1); start_elem = '0;
        dst_idx = 5'd2;    bad_op("R7 overlap", 2'b00, 1'b1); dst_idx = 5'd4;
        dst_idx = 5'd0;    bad_op("R7 dst v0 masked", 2'b00, 1'b0);
        legal_op("R7 dst v0 unmasked legal", 2'b00, 128'h20, '0, '0, 1'b1, 8, 1'b0);
        dst_idx = 5'd4;
        bad_op("R7 reserved mode", 2'b11, 1'b1);
        vec_len = 8'd129;
        @(negedge clk);
        start = 1'b1; mode = 2'b00;
        @(negedge clk);
        start = 1'b0;
        chk_int("R7 length too big", int'({done, illegal}), 3);
        @(negedge clk);
        // R9 start while busy ignored
        legal_op("R9 busy start ignored", 2'b10, 128'h100, 128'hF0F0, '0, 1'b1, 20, 1'b1);
        // random
        for (int k = 0; k < 60; k++) begin
            logic [W-1:0] s, o, e;
            logic [1:0] m;
            int vl;
            s = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
              & {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 5) == 0) s = '0;
            o = {$urandom, $urandom, $urandom, $urandom};
            e = {$urandom, $urandom, $urandom, $urandom};
            m = 2'($urandom_range(0, 2));
            vl = $urandom_range(0, 128);
            legal_op("R1 R2 R3 R5 random", m, s, o, e, 1'($urandom_range(0, 1)), vl, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule